// File: doc/BRIEF.md
# PCM Codec Serial Data Port

This block is the digital serial interface of a telephony PCM codec that uses long frame sync timing. On the transmit side it keeps the latest 8-bit companded code from an on-chip encoder in a holding register. It sends that code, most significant (sign) bit first, on a data output whose tri-state pad buffer it controls. Transmission is framed by a transmit frame sync pin and a transmit bit clock pin. On the receive side it collects eight bits from a data input, framed by a receive frame sync and a bit clock. It then hands the code to a decoder together with a one-cycle valid strobe.

All pin inputs are brought into a fast system clock through two-flop synchronisers, and edges are detected in that domain. The bit clocks therefore never act as clocks. The transmit and receive paths use opposite bit-clock edges: rising edges launch bits and falling edges sample them. In synchronous mode the receive path takes its falling edges from the transmit bit clock and ignores the receive bit clock pin. In asynchronous mode each direction uses its own clock.

Top module: `pcm_serial_port`

## Requirements
- R1: During and right after reset, `tx_oe_o`, `tx_dat_o` and `rx_valid_o` are 0 and `rx_code_o` is 0x00.
- R2: The output enable turns on at the later of the transmit frame sync rising edge and a transmit bit clock rising edge. If the bit clock is already high when frame sync rises, it turns on at the frame sync edge; otherwise it stays off until the next bit clock rise. The first bit driven is bit 7 (the sign bit) of the held code.
- R3: Each of the next seven transmit bit clock rising edges advances the output by one bit, in the order bit 6 down to bit 0.
- R4: The output enable turns off at the later of two events: the transmit bit clock falling edge after the eighth bit, or transmit frame sync going low. It stays on for all eight bits even if frame sync falls earlier.
- R5: A code presented with `enc_load_i` high for one system clock is sent in the next frame. A frame that starts with no new load resends the previous code.
- R6: After a receive frame sync rising edge, `rx_dat_i` is sampled on the next eight falling edges of the selected receive bit clock. The first sample becomes bit 7 of the code. After the eighth sample `rx_valid_o` is high for exactly one system clock, and `rx_code_o` carries the code and holds it afterwards.
- R7: With `sync_mode_i` = 1 the receive path uses the transmit bit clock, and activity on `rx_bclk_i` has no effect. With `sync_mode_i` = 0 it uses `rx_bclk_i` only, so a silent `rx_bclk_i` produces no strobe.
- R8: A frame sync rising edge in the middle of a frame aborts the frame on that side. The bit count restarts at zero, transmit reloads the held code, and a partly received code is discarded without a strobe.
- R9: Between pulses, each frame sync input stays low for at least 16 system clocks (160 ns at 100 MHz). This is an input timing rule that the environment must meet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode_i | input | 1 | 1: receive uses the transmit bit clock; 0: separate clocks |
| tx_fs_i | input | 1 | Transmit frame sync pin |
| tx_bclk_i | input | 1 | Transmit bit clock pin |
| enc_code_i | input | 8 | Code from the encoder |
| enc_load_i | input | 1 | One-cycle load strobe for `enc_code_i` |
| tx_dat_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Enable for the tri-state transmit pad buffer |
| rx_fs_i | input | 1 | Receive frame sync pin |
| rx_bclk_i | input | 1 | Receive bit clock pin |
| rx_dat_i | input | 1 | Serial receive data pin |
| rx_code_o | output | 8 | Last received code, toward the decoder |
| rx_valid_o | output | 1 | One-cycle strobe: a new code is on `rx_code_o` |

## Verification
The bench sweeps frames that start with frame sync rising either before or after the bit clock goes high. It also moves the frame sync fall to several bit positions, including past the eighth bit. A design that picks the wrong one of the two edges would either miss the sign bit or shift one bit too early. A design that drops the enable on frame sync alone would cut off the last bits. Frames without a new load check that the held code is resent rather than cleared. A truncated frame followed by a fresh one checks that a restart realigns both directions and discards the partial receive code. In synchronous mode the receive bit clock pin is driven with fast junk, and in asynchronous mode it is held still. Either would break a design that chooses the wrong clock source.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned PCM_CODE_W   = 8;
  localparam int unsigned PCM_SYNC_DEF = 2;
  // Bit positions of the synchronised pin vector
  localparam int unsigned PIN_TX_FS   = 0;
  localparam int unsigned PIN_TX_BCLK = 1;
  localparam int unsigned PIN_RX_FS   = 2;
  localparam int unsigned PIN_RX_BCLK = 3;
  localparam int unsigned PIN_RX_DAT  = 4;
  localparam int unsigned PIN_COUNT   = 5;
endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-1:0], pin_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign level_o[g] = chain_q[STAGES-1];
    assign rise_o[g]  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o[g]  = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_lvl_i,
  input  logic              fs_rise_i,
  input  logic              bclk_lvl_i,
  input  logic              bclk_rise_i,
  input  logic              bclk_fall_i,
  input  logic [CODE_W-1:0] enc_code_i,
  input  logic              enc_load_i,
  output logic              dat_o,
  output logic              oe_o
);
  localparam int unsigned CNT_W = $clog2(CODE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W);

  logic [CODE_W-1:0] hold_q, hold_d, sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              oe_q, oe_d, pend_q, pend_d, done_q, done_d;
  logic              last_fall;

  assign last_fall = oe_q & bclk_fall_i & (cnt_q == LAST);

  always_comb begin
    hold_d = enc_load_i ? enc_code_i : hold_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    oe_d   = oe_q;
    pend_d = pend_q;
    done_d = done_q;
    if (fs_rise_i) begin
      // new frame (or restart): reload and count from zero
      sh_d   = hold_q;
      done_d = 1'b0;
      if (bclk_lvl_i) begin
        oe_d = 1'b1; pend_d = 1'b0; cnt_d = CNT_W'(1);
      end else begin
        oe_d = 1'b0; pend_d = 1'b1; cnt_d = '0;
      end
    end else begin
      if (pend_q) begin
        if (!fs_lvl_i) begin
          pend_d = 1'b0;
        end else if (bclk_rise_i) begin
          oe_d = 1'b1; pend_d = 1'b0; cnt_d = CNT_W'(1);
        end
      end
      if (oe_q) begin
        if (bclk_rise_i && (cnt_q < LAST)) begin
          sh_d  = {sh_q[CODE_W-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
        end
        if (last_fall) done_d = 1'b1;
        if ((done_q || last_fall) && !fs_lvl_i) begin
          oe_d = 1'b0; done_d = 1'b0; cnt_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; sh_q <= '0; cnt_q <= '0;
      oe_q <= 1'b0; pend_q <= 1'b0; done_q <= 1'b0;
    end else begin
      hold_q <= hold_d; sh_q <= sh_d; cnt_q <= cnt_d;
      oe_q <= oe_d; pend_q <= pend_d; done_q <= done_d;
    end
  end

  assign dat_o = oe_q & sh_q[CODE_W-1];
  assign oe_o  = oe_q;

  AST_OE_NEEDS_FS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> fs_lvl_i); // R2
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3
  AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && (cnt_q < LAST) && !fs_rise_i) |=> oe_q); // R4
  AST_DROP_FS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> ($past(fs_rise_i) || !$past(fs_lvl_i))); // R4
endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_rise_i,
  input  logic              bclk_fall_i,
  input  logic              dat_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);
  localparam int unsigned CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic [CODE_W-1:0] sh_q, sh_d, code_q, code_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              arm_q, arm_d, valid_q, valid_d;

  always_comb begin
    sh_d    = sh_q;
    code_d  = code_q;
    cnt_d   = cnt_q;
    arm_d   = arm_q;
    valid_d = 1'b0;
    if (fs_rise_i) begin
      arm_d = 1'b1;
      cnt_d = '0;
    end else if (arm_q && bclk_fall_i) begin
      sh_d = {sh_q[CODE_W-2:0], dat_i};
      if (cnt_q == LAST) begin
        arm_d   = 1'b0;
        cnt_d   = '0;
        code_d  = {sh_q[CODE_W-2:0], dat_i};
        valid_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; code_q <= '0; cnt_q <= '0; arm_q <= 1'b0; valid_q <= 1'b0;
    end else begin
      sh_q <= sh_d; code_q <= code_d; cnt_q <= cnt_d; arm_q <= arm_d; valid_q <= valid_d;
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R6
  AST_VALID_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !arm_q); // R6
  AST_RESTART_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise_i |=> !valid_q); // R8
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned CODE_W      = PCM_CODE_W,
  parameter int unsigned SYNC_STAGES = PCM_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode_i,
  input  logic              tx_fs_i,
  input  logic              tx_bclk_i,
  input  logic [CODE_W-1:0] enc_code_i,
  input  logic              enc_load_i,
  output logic              tx_dat_o,
  output logic              tx_oe_o,
  input  logic              rx_fs_i,
  input  logic              rx_bclk_i,
  input  logic              rx_dat_i,
  output logic [CODE_W-1:0] rx_code_o,
  output logic              rx_valid_o
);
  logic                 rst_s_n;
  logic [PIN_COUNT-1:0] pins, lvl, rise, fall;
  logic                 rx_edge;

  pcm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  always_comb begin
    pins              = '0;
    pins[PIN_TX_FS]   = tx_fs_i;
    pins[PIN_TX_BCLK] = tx_bclk_i;
    pins[PIN_RX_FS]   = rx_fs_i;
    pins[PIN_RX_BCLK] = rx_bclk_i;
    pins[PIN_RX_DAT]  = rx_dat_i;
  end

  pcm_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .pin_i(pins),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  // receive clock source: transmit clock in synchronous mode
  assign rx_edge = sync_mode_i ? fall[PIN_TX_BCLK] : fall[PIN_RX_BCLK];

  pcm_tx_shifter #(.CODE_W(CODE_W)) u_tx (
    .clk(clk), .rst_n(rst_s_n),
    .fs_lvl_i(lvl[PIN_TX_FS]), .fs_rise_i(rise[PIN_TX_FS]),
    .bclk_lvl_i(lvl[PIN_TX_BCLK]), .bclk_rise_i(rise[PIN_TX_BCLK]),
    .bclk_fall_i(fall[PIN_TX_BCLK]),
    .enc_code_i(enc_code_i), .enc_load_i(enc_load_i),
    .dat_o(tx_dat_o), .oe_o(tx_oe_o)
  );

  pcm_rx_capture #(.CODE_W(CODE_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n),
    .fs_rise_i(rise[PIN_RX_FS]), .bclk_fall_i(rx_edge),
    .dat_i(lvl[PIN_RX_DAT]),
    .code_o(rx_code_o), .valid_o(rx_valid_o)
  );

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> (!tx_oe_o && !rx_valid_o)); // R1
endmodule

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_mode = 1'b0;
  logic       fs = 1'b0;
  logic       bclk = 1'b0;
  logic [7:0] enc_code = 8'h00;
  logic       enc_load = 1'b0;
  logic       rxd = 1'b0;
  logic [1:0] rxm = 2'd0;   // 0 follow bclk, 1 junk, 2 held low
  logic       junk = 1'b0;
  logic       rx_bclk;
  logic       tx_dat, tx_oe, rx_valid;
  logic [7:0] rx_code;

  int total = 0;
  int bad = 0;
  int vcount = 0;
  logic [7:0] vcode = 8'h00;
  int lowlen = 1000;
  logic fs_prev = 1'b0;

  always #5 clk = ~clk;

  always begin
    repeat (3) @(posedge clk);
    junk = ~junk;
  end

  assign rx_bclk = (rxm == 2'd0) ? bclk : ((rxm == 2'd1) ? junk : 1'b0);

  pcm_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .sync_mode_i(sync_mode),
    .tx_fs_i(fs), .tx_bclk_i(bclk), .enc_code_i(enc_code), .enc_load_i(enc_load),
    .tx_dat_o(tx_dat), .tx_oe_o(tx_oe),
    .rx_fs_i(fs), .rx_bclk_i(rx_bclk), .rx_dat_i(rxd),
    .rx_code_o(rx_code), .rx_valid_o(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (rx_valid === 1'b1) begin
      vcount <= vcount + 1;
      vcode  <= rx_code;
    end
  end

  // R9: frame sync low gap monitor
  always @(posedge clk) begin
    if (fs && !fs_prev) begin
      total++;
      if (lowlen < 16) begin
        bad++;
        $display("FAIL R9 actual=%0d expected>=16", lowlen);
      end
    end
    if (!fs) lowlen = (lowlen < 1000) ? lowlen + 1 : lowlen;
    else     lowlen = 0;
    fs_prev = fs;
  end

  task automatic load(input logic [7:0] c);
    @(negedge clk);
    enc_code = c;
    enc_load = 1'b1;
    tick(1);
    enc_load = 1'b0;
  endtask

  task automatic frame(input logic [7:0] txc, input logic [7:0] rxc, input bit late_b,
                       input int drop, input int nbits, input string tag);
    string t;
    if (!late_b) begin
      fs = 1'b1;
      tick(5);
      chk(tx_oe == 1'b0, "R2", tx_oe, 0);
    end
    for (int i = 0; i < nbits; i++) begin
      bclk = 1'b1;
      rxd  = rxc[7-i];
      if (i == 0 && late_b) begin
        tick(2); fs = 1'b1; tick(5);
      end else begin
        tick(7);
      end
      t = (tag != "") ? tag : ((i == 0) ? "R2" : "R3");
      chk(tx_oe == 1'b1 && tx_dat == txc[7-i], t, {tx_oe, tx_dat}, {1'b1, txc[7-i]});
      tick(3);
      bclk = 1'b0;
      if (i == drop) fs = 1'b0;
      tick(10);
    end
    if (nbits == 8) begin
      if (drop >= 8) begin
        chk(tx_oe == 1'b1, "R4", tx_oe, 1);
        fs = 1'b0;
        tick(5);
      end
      chk(tx_oe == 1'b0, "R4", tx_oe, 0);
    end else begin
      fs = 1'b0;
    end
    tick(20);
  endtask

  initial begin
    logic [7:0] exp_tx;
    logic [7:0] rxc;
    int v0;
    exp_tx = 8'h00;
    tick(3);
    chk(tx_oe == 1'b0 && rx_valid == 1'b0 && rx_code == 8'h00, "R1",
        {tx_oe, rx_valid, rx_code}, 0);
    rst_n = 1'b1;
    tick(4);
    chk(tx_oe == 1'b0 && tx_dat == 1'b0 && rx_valid == 1'b0 && rx_code == 8'h00, "R1",
        {tx_oe, tx_dat, rx_valid, rx_code}, 0);

    // main sweep: edge order, fs fall position, clock mode, load/resend
    for (int k = 0; k < 12; k++) begin
      bit resend;
      int drop;
      resend    = (k % 4 == 3);
      sync_mode = k[1];
      rxm       = k[1] ? 2'd1 : 2'd0;
      drop      = (k % 3 == 0) ? 10 : (k * 5) % 8;
      if (!resend) begin
        exp_tx = 8'((k * 53 + 17) & 255);
        load(exp_tx);
      end
      rxc = 8'((k * 29 + 200) & 255) ^ 8'h5A;
      v0 = vcount;
      frame(exp_tx, rxc, k[0], drop, 8, resend ? "R5" : "");
      chk(vcount == v0 + 1 && vcode == rxc, k[1] ? "R7" : "R6", vcode, rxc);
    end

    // asynchronous mode with a silent receive clock: no strobe
    sync_mode = 1'b0;
    rxm = 2'd2;
    v0 = vcount;
    frame(exp_tx, 8'hC3, 1'b0, 10, 8, "R5");
    chk(vcount == v0, "R7", vcount - v0, 0);

    // mid-frame restart on both sides
    rxm = 2'd0;
    exp_tx = 8'hB6;
    load(exp_tx);
    v0 = vcount;
    frame(exp_tx, 8'hFF, 1'b0, 1, 3, "R8");
    frame(exp_tx, 8'h29, 1'b1, 10, 8, "R8");
    chk(vcount == v0 + 1 && vcode == 8'h29, "R8", vcode, 8'h29);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule